// File: doc/BRIEF.md
# Coprocessor Context Save Sequencer

This block is the main-processor side of a coprocessor state save. A decoded save request supplies a destination address and the current supervisor bit, which is bit 13 of the status register. A request at user level is refused with a privilege-violation pulse, and no coprocessor register is touched.

At supervisor level the sequencer reads a format word from the coprocessor's save register. It re-reads while the coprocessor reports "not ready". It then stores the format word, followed by a null halfword, at the destination address. Next it copies the coprocessor's internal state, one 32-bit word at a time, from the operand register to the following addresses. The number of state bytes comes from the low byte of the format word. The count does not include the format word and its null partner.

An invalid format code, or a byte count that is not a multiple of four, makes the block write an abort mask to the coprocessor control register. Only after that write does it report a format error. Every coprocessor register access and every memory write is a valid/ready handshake.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, busy, cpValid, memValid, donePulse, privErr and fmtErr are all low.
- R2: A request taken with reqSuper low produces exactly one privErr pulse and no coprocessor access or memory write of any kind.
- R3: A request taken with reqSuper high reads the save register (cpSel = 1, cpWrite low). A format word whose upper byte is 8'h01 (not ready) causes the save register to be read again, until some other code is returned.
- R4: The format word (cpRdata bits 15:0) is written first, to reqAddr, placed in memWdata bits 31:16 with bits 15:0 zero.
- R5: The low byte of the format word is a byte count N. N/4 words are read from the operand register (cpSel = 2) and written in arrival order to reqAddr+4, reqAddr+8, and so on, with the address rising by 4 per write.
- R6: A valid format word with N = 0 completes with donePulse right after the format word write, and the operand register is not read.
- R7: An upper byte of 8'h02 (invalid), or an N that is not a multiple of 4, causes one write of ABORT_MASK to the control register (cpSel = 0, cpWrite high). A single fmtErr pulse follows that write, and no memory write is made.
- R8: While cpValid or memValid is high without its ready, the block holds the valid and all select, address and data outputs stable.
- R9: Each request ends with exactly one of donePulse, privErr or fmtErr, one cycle wide, after which busy falls.
- R10: A reqValid that arrives while busy is high is ignored and does not change the running save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Save request, taken when idle |
| reqAddr | input | ADDR_W | Destination base address |
| reqSuper | input | 1 | Supervisor bit (status register bit 13) at request time |
| busy | output | 1 | Sequencer is not idle |
| cpValid | output | 1 | Coprocessor register access request |
| cpWrite | output | 1 | Access is a write |
| cpSel | output | 2 | Register select: 0 control, 1 save, 2 operand |
| cpWdata | output | DATA_W | Write data for coprocessor register |
| cpReady | input | 1 | Coprocessor access accepted |
| cpRdata | input | DATA_W | Read data, valid with cpReady |
| memValid | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Memory write address |
| memWdata | output | DATA_W | Memory write data |
| memReady | input | 1 | Memory write accepted |
| donePulse | output | 1 | Save completed |
| privErr | output | 1 | Privilege violation |
| fmtErr | output | 1 | Format error |

## Verification
The bench goes after these corner cases: user-level requests, zero-length saves, strings of not-ready codes, invalid codes, byte counts that are not a multiple of four, and the longest allowed length, all under random ready stalls. A sequencer that checks privilege late would show a save-register read in the coprocessor log. One that skips the zero case would read the operand register or hang. A design that faults before aborting would raise fmtErr with no control write ahead of it, or one cycle too early. Off-by-one counting shows up as a missing or extra memory word. Dropping a held output under stall shows up as an instability count, and a second request during a save would appear as a stray privErr.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

  localparam int CP_SEL_W = 2;

  localparam logic [CP_SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [CP_SEL_W-1:0] SEL_SAVE = 2'd1;
  localparam logic [CP_SEL_W-1:0] SEL_OPER = 2'd2;

  localparam logic [7:0] CODE_NOT_READY = 8'h01;
  localparam logic [7:0] CODE_INVALID   = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDSAVE,
    ST_EVAL,
    ST_ABORT,
    ST_WRFMT,
    ST_RDOPER,
    ST_WRDATA,
    ST_DONE,
    ST_PRIV,
    ST_FERR
  } seqState_t;

  typedef enum logic [1:0] {
    FMT_WAIT,
    FMT_BAD,
    FMT_GOOD
  } fmtClass_t;

  typedef struct packed {
    logic takeReq;
    logic takeFmt;
    logic fmtStored;
    logic takeWord;
    logic wordStored;
    logic pickFmt;
  } dpCtl_t;

endpackage

// File: rtl/ctx_save_dp.sv
module ctx_save_dp
  import ctx_save_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] cpRdata,
  output fmtClass_t         fmtClass,
  output logic              lenZero,
  output logic              lastWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int FMT_W      = 16;
  localparam int LEN_W      = 8;
  localparam int PAD_W      = DATA_W - FMT_W;

  logic [ADDR_W-1:0] addrReg;
  logic [FMT_W-1:0]  fmtReg;
  logic [LEN_W-1:0]  remReg;
  logic [DATA_W-1:0] dataReg;

  logic [LEN_W-1:0] lenByte;
  logic [7:0]       codeByte;

  assign lenByte  = fmtReg[LEN_W-1:0];
  assign codeByte = fmtReg[FMT_W-1:LEN_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      fmtReg  <= '0;
      remReg  <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.takeReq)
        addrReg <= reqAddr;
      else if (ctl.fmtStored || ctl.wordStored)
        addrReg <= addrReg + ADDR_W'(WORD_BYTES);

      if (ctl.takeFmt)
        fmtReg <= cpRdata[FMT_W-1:0];

      if (ctl.fmtStored)
        remReg <= lenByte;
      else if (ctl.wordStored)
        remReg <= remReg - LEN_W'(WORD_BYTES);

      if (ctl.takeWord)
        dataReg <= cpRdata;
    end
  end

  always_comb begin
    if (codeByte == CODE_NOT_READY)
      fmtClass = FMT_WAIT;
    else if ((codeByte == CODE_INVALID) || ((lenByte % LEN_W'(WORD_BYTES)) != '0))
      fmtClass = FMT_BAD;
    else
      fmtClass = FMT_GOOD;
  end

  assign lenZero  = (lenByte == '0);
  assign lastWord = (remReg == LEN_W'(WORD_BYTES));
  assign memAddr  = addrReg;
  assign memWdata = ctl.pickFmt ? {fmtReg, {PAD_W{1'b0}}} : dataReg;

  // R5
  no_rem_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wordStored |-> (remReg >= LEN_W'(WORD_BYTES)));

endmodule

// File: rtl/ctx_save_ctrl.sv
module ctx_save_ctrl
  import ctx_save_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ABORT_MASK = 32'h0000_0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqSuper,
  input  logic                cpReady,
  input  logic                memReady,
  input  fmtClass_t           fmtClass,
  input  logic                lenZero,
  input  logic                lastWord,
  output logic                busy,
  output logic                cpValid,
  output logic                cpWrite,
  output logic [CP_SEL_W-1:0] cpSel,
  output logic [DATA_W-1:0]   cpWdata,
  output logic                memValid,
  output logic                donePulse,
  output logic                privErr,
  output logic                fmtErr,
  output dpCtl_t              ctl
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    cpValid   = 1'b0;
    cpWrite   = 1'b0;
    cpSel     = SEL_CTRL;
    cpWdata   = '0;
    memValid  = 1'b0;
    donePulse = 1'b0;
    privErr   = 1'b0;
    fmtErr    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.takeReq = 1'b1;
          stateNext   = reqSuper ? ST_RDSAVE : ST_PRIV;
        end
      end
      ST_RDSAVE: begin
        cpValid = 1'b1;
        cpSel   = SEL_SAVE;
        if (cpReady) begin
          ctl.takeFmt = 1'b1;
          stateNext   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        unique case (fmtClass)
          FMT_WAIT: stateNext = ST_RDSAVE;
          FMT_BAD:  stateNext = ST_ABORT;
          default:  stateNext = ST_WRFMT;
        endcase
      end
      ST_ABORT: begin
        cpValid = 1'b1;
        cpWrite = 1'b1;
        cpSel   = SEL_CTRL;
        cpWdata = DATA_W'(ABORT_MASK);
        if (cpReady) stateNext = ST_FERR;
      end
      ST_WRFMT: begin
        memValid    = 1'b1;
        ctl.pickFmt = 1'b1;
        if (memReady) begin
          ctl.fmtStored = 1'b1;
          stateNext     = lenZero ? ST_DONE : ST_RDOPER;
        end
      end
      ST_RDOPER: begin
        cpValid = 1'b1;
        cpSel   = SEL_OPER;
        if (cpReady) begin
          ctl.takeWord = 1'b1;
          stateNext    = ST_WRDATA;
        end
      end
      ST_WRDATA: begin
        memValid = 1'b1;
        if (memReady) begin
          ctl.wordStored = 1'b1;
          stateNext      = lastWord ? ST_DONE : ST_RDOPER;
        end
      end
      ST_DONE: begin
        donePulse = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_PRIV: begin
        privErr   = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_FERR: begin
        fmtErr    = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R8
  cp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpValid && !cpReady) |=> (cpValid && $stable(cpSel) && $stable(cpWrite) && $stable(cpWdata)));

  // R2
  priv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !reqSuper) |=> (privErr && !cpValid && !memValid));

  // R7
  abort_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> $past(cpValid && cpWrite && cpReady && (cpSel == SEL_CTRL)));

  // R9
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy));

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_save_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ABORT_MASK = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  output logic              busy,
  output logic              cpValid,
  output logic              cpWrite,
  output logic [1:0]        cpSel,
  output logic [DATA_W-1:0] cpWdata,
  input  logic              cpReady,
  input  logic [DATA_W-1:0] cpRdata,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  output logic              donePulse,
  output logic              privErr,
  output logic              fmtErr
);

  dpCtl_t    ctl;
  fmtClass_t fmtClass;
  logic      lenZero;
  logic      lastWord;

  ctx_save_ctrl #(
    .DATA_W    (DATA_W),
    .ABORT_MASK(ABORT_MASK)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSuper (reqSuper),
    .cpReady  (cpReady),
    .memReady (memReady),
    .fmtClass (fmtClass),
    .lenZero  (lenZero),
    .lastWord (lastWord),
    .busy     (busy),
    .cpValid  (cpValid),
    .cpWrite  (cpWrite),
    .cpSel    (cpSel),
    .cpWdata  (cpWdata),
    .memValid (memValid),
    .donePulse(donePulse),
    .privErr  (privErr),
    .fmtErr   (fmtErr),
    .ctl      (ctl)
  );

  ctx_save_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .cpRdata (cpRdata),
    .fmtClass(fmtClass),
    .lenZero (lenZero),
    .lastWord(lastWord),
    .memAddr (memAddr),
    .memWdata(memWdata)
  );

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWdata)));

  // R4
  fmt_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memValid) |=> (!memValid || (memAddr == $past(memAddr)) || $past(cpValid) || $past(memValid)));

endmodule

// File: tb/ctx_save_seq_test.sv
module ctx_save_seq_test;

  localparam int          ADDR_W = 32;
  localparam int          DATA_W = 32;
  localparam logic [31:0] ABORT  = 32'h0000_0001;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqSuper = 1'b0;
  logic              busy, cpValid, cpWrite, memValid, donePulse, privErr, fmtErr;
  logic [1:0]        cpSel;
  logic [DATA_W-1:0] cpWdata, memWdata;
  logic [ADDR_W-1:0] memAddr;
  logic              cpReady = 1'b0, memReady = 1'b0;
  logic [DATA_W-1:0] cpRdata = '0;

  always #10 clk = ~clk;

  ctx_save_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABORT_MASK(ABORT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSuper(reqSuper),
    .busy(busy), .cpValid(cpValid), .cpWrite(cpWrite), .cpSel(cpSel), .cpWdata(cpWdata),
    .cpReady(cpReady), .cpRdata(cpRdata), .memValid(memValid), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .donePulse(donePulse), .privErr(privErr),
    .fmtErr(fmtErr)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] saveSeq [0:7];
  int          saveN, saveIdx;
  logic [31:0] memLogA [0:79];
  logic [31:0] memLogD [0:79];
  int          memCnt, saveRd, operRd, ctrlWr, otherCp, ctrlCyc, ferrCyc;
  int          nDone, nPriv, nFerr, cyc, unstable, opIdx;
  logic [31:0] ctrlData, opBase;

  logic        pCpV = 0, pCpR = 0, pCpW = 0, pMemV = 0, pMemR = 0;
  logic [1:0]  pSel = 0;
  logic [31:0] pCpD = 0, pMemA = 0, pMemD = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    memCnt = 0; saveRd = 0; operRd = 0; ctrlWr = 0; otherCp = 0;
    ctrlCyc = 0; ferrCyc = 0; nDone = 0; nPriv = 0; nFerr = 0;
    unstable = 0; opIdx = 0; saveIdx = 0; ctrlData = '0;
  endtask

  // Responder models for the coprocessor registers and memory, plus pulse monitor
  initial begin
    cyc = 0;
    clearLogs();
    forever begin
      @(negedge clk);
      cyc++;
      if (donePulse) nDone++;
      if (privErr) nPriv++;
      if (fmtErr) begin nFerr++; ferrCyc = cyc; end
      if (pCpV && !pCpR &&
          !(cpValid && cpSel == pSel && cpWrite == pCpW && cpWdata == pCpD)) unstable++;
      if (pMemV && !pMemR &&
          !(memValid && memAddr == pMemA && memWdata == pMemD)) unstable++;
      cpReady = cpValid && (($urandom % 3) != 0);
      if (cpReady) begin
        if (cpWrite) begin
          if (cpSel == 2'd0) begin ctrlWr++; ctrlData = cpWdata; ctrlCyc = cyc; end
          else otherCp++;
        end else if (cpSel == 2'd1) begin
          saveRd++;
          cpRdata = {16'h0, saveSeq[saveIdx]};
          if (saveIdx < saveN - 1) saveIdx++;
        end else if (cpSel == 2'd2) begin
          operRd++;
          cpRdata = opBase + opIdx;
          opIdx++;
        end else otherCp++;
      end
      memReady = memValid && (($urandom % 3) != 0);
      if (memReady) begin
        if (memCnt < 80) begin
          memLogA[memCnt] = memAddr;
          memLogD[memCnt] = memWdata;
        end
        memCnt++;
      end
      pCpV = cpValid; pCpR = cpReady; pCpW = cpWrite; pSel = cpSel; pCpD = cpWdata;
      pMemV = memValid; pMemR = memReady; pMemA = memAddr; pMemD = memWdata;
    end
  end

  task automatic runOp(input logic [31:0] base, input bit sup, input bit midReq);
    int n;
    @(posedge clk);
    clearLogs();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = base; reqSuper = sup;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
      if (midReq && n == 3) begin
        reqValid = 1'b1; reqSuper = 1'b0; reqAddr = ~base;
      end else reqValid = 1'b0;
    end
    reqValid = 1'b0;
    chk(n < 3000, "R9", "watchdog busy", n, 3000);
    repeat (2) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic expectOp(input logic [31:0] base, input bit sup, input string tag);
    logic [15:0] fw;
    logic [7:0]  code, len;
    bit          bad;
    int          words;
    chk(unstable == 0, "R8", {tag, " held outputs"}, unstable, 0);
    if (!sup) begin
      chk(nPriv == 1, "R2", {tag, " privErr count"}, nPriv, 1);
      chk(saveRd + operRd + ctrlWr + otherCp == 0, "R2", {tag, " cp accesses"},
          saveRd + operRd + ctrlWr + otherCp, 0);
      chk(memCnt == 0, "R2", {tag, " mem writes"}, memCnt, 0);
      chk(nDone + nFerr == 0, "R9", {tag, " other pulses"}, nDone + nFerr, 0);
      return;
    end
    fw   = saveSeq[saveN-1];
    code = fw[15:8];
    len  = fw[7:0];
    bad  = (code == 8'h02) || (len[1:0] != 2'b00);
    chk(saveRd == saveN, "R3", {tag, " save reads"}, saveRd, saveN);
    chk(nPriv == 0, "R9", {tag, " privErr"}, nPriv, 0);
    chk(otherCp == 0, "R3", {tag, " stray cp access"}, otherCp, 0);
    if (bad) begin
      chk(ctrlWr == 1, "R7", {tag, " abort writes"}, ctrlWr, 1);
      chk(ctrlData == ABORT, "R7", {tag, " abort mask"}, ctrlData, ABORT);
      chk(nFerr == 1, "R7", {tag, " fmtErr count"}, nFerr, 1);
      chk(ctrlCyc < ferrCyc, "R7", {tag, " abort before error"}, ctrlCyc, ferrCyc);
      chk(memCnt == 0, "R7", {tag, " no mem writes"}, memCnt, 0);
      chk(nDone == 0, "R9", {tag, " done"}, nDone, 0);
    end else begin
      words = len / 4;
      chk(ctrlWr == 0, "R5", {tag, " control writes"}, ctrlWr, 0);
      chk(nDone == 1, "R9", {tag, " done count"}, nDone, 1);
      chk(nFerr == 0, "R9", {tag, " fmtErr"}, nFerr, 0);
      chk(operRd == words, (words == 0) ? "R6" : "R5", {tag, " operand reads"}, operRd, words);
      chk(memCnt == words + 1, (words == 0) ? "R6" : "R5", {tag, " mem writes"}, memCnt, words + 1);
      if (memCnt >= 1) begin
        chk(memLogA[0] == base, "R4", {tag, " format addr"}, memLogA[0], base);
        chk(memLogD[0] == {fw, 16'h0000}, "R4", {tag, " format data"}, memLogD[0], {fw, 16'h0000});
      end
      for (int i = 1; i <= words && i < memCnt && i < 80; i++) begin
        chk(memLogA[i] == base + 32'(4 * i), "R5", {tag, " word addr"}, memLogA[i], base + 32'(4 * i));
        chk(memLogD[i] == opBase + 32'(i - 1), "R5", {tag, " word data"}, memLogD[i], opBase + 32'(i - 1));
      end
    end
  endtask

  task automatic directed(input logic [31:0] base, input bit sup, input logic [15:0] fw,
                          input int waits, input bit midReq, input string tag);
    for (int i = 0; i < waits; i++) saveSeq[i] = {8'h01, 8'(i * 7)};
    saveSeq[waits] = fw;
    saveN  = waits + 1;
    opBase = 32'hC0DE_0000 + base;
    runOp(base, sup, midReq);
    expectOp(base, sup, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    saveN = 1;
    saveSeq[0] = 16'h1000;
    opBase = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({busy, cpValid, memValid, donePulse, privErr, fmtErr} == 6'b0, "R1", "reset outputs",
        {busy, cpValid, memValid, donePulse, privErr, fmtErr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, cpValid, memValid} == 3'b0, "R1", "idle after reset", {busy, cpValid, memValid}, 0);

    directed(32'h0000_1000, 1'b0, 16'h1010, 0, 1'b0, "R2 user level");
    directed(32'h0000_2000, 1'b1, 16'h1000, 0, 1'b0, "R6 zero length");
    directed(32'h0000_3000, 1'b1, 16'h2004, 0, 1'b0, "R5 one word");
    directed(32'h0000_4000, 1'b1, 16'h30FC, 0, 1'b0, "R5 max length");
    directed(32'h0000_5000, 1'b1, 16'h4006, 0, 1'b0, "R7 odd length");
    directed(32'h0000_6000, 1'b1, 16'h0210, 0, 1'b0, "R7 invalid code");
    directed(32'h0000_7000, 1'b1, 16'h5008, 3, 1'b0, "R3 not ready");
    directed(32'h0000_8000, 1'b1, 16'h6020, 0, 1'b1, "R10 busy request");
    directed(32'h0000_9000, 1'b1, 16'h0203, 2, 1'b0, "R7 invalid after wait");

    for (int it = 0; it < 40; it++) begin
      int          waits;
      logic [7:0]  code, len;
      logic [31:0] base;
      bit          sup;
      base  = $urandom & 32'hFFFF_FFFC;
      sup   = ($urandom % 8) != 0;
      waits = $urandom % 3;
      code  = (($urandom % 10) == 0) ? 8'h02 : 8'(8'h10 + ($urandom % 200));
      len   = (($urandom % 6) == 0) ? 8'($urandom) : 8'(($urandom % 64) * 4);
      for (int i = 0; i < waits; i++) saveSeq[i] = {8'h01, 8'($urandom)};
      saveSeq[waits] = {code, len};
      saveN  = waits + 1;
      opBase = $urandom;
      runOp(base, sup, 1'b0);
      expectOp(base, sup, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule